// File: doc/BRIEF.md
# Maskable Parallel Signature Analyzer

This block holds a test-cell word that watches a parallel data bus. In sample mode a qualified bus word is copied into the cell word as it is. In signature mode each qualified bus word is folded into a running signature by a multiple-input linear-feedback shift register. A per-bit mask removes chosen bus lines from the fold. A tap word, set at run time, chooses the feedback polynomial.

A test controller picks the mode and drives the qualifying strobe. It pulses the start input to clear the signature. When the run is over, it scans the word out serially, least significant bit first, and compares it with a precomputed expected signature. The scan path also lets the controller preload a seed. The word is shown in parallel on `sig_o`. Choosing when to raise the strobe is left to logic outside the block.

Top module: `masked_sig_analyzer`

## Requirements
- R1: After reset is released, `sig_o` and `scan_out_o` are all zero.
- R2: A cycle with `start_i` high clears the word to zero on the next edge. This overrides scanning, sampling and compression.
- R3: With `scan_en_i` high, each edge shifts the word one place toward bit 0 and loads `scan_in_i` into bit WIDTH-1. `scan_out_o` always shows bit 0, so the word leaves least significant bit first. WIDTH shifts with `scan_out_o` looped back to `scan_in_i` leave the word unchanged.
- R4: While `scan_en_i` is high, the strobe and the mode have no effect on the word.
- R5: With `mode_i` = 2'b01 (sample) and `strobe_i` high, the word takes the bus value on the next edge.
- R6: With `mode_i` = 2'b10 (signature) and `strobe_i` high, the next word is (word << 1) XOR (taps_i if word bit WIDTH-1 was 1, else 0) XOR (bus_i AND NOT mask_i). This is the default Galois variant.
- R7: A bus bit whose `mask_i` bit is 1 has no effect on the signature.
- R8: With `strobe_i` low, or with `mode_i` = 2'b00 or 2'b11, the word holds its value.
- R9: `taps_i` sets the feedback polynomial. Different tap words give the signatures that R6 predicts for the same data stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_i | input | WIDTH | Monitored data bus |
| strobe_i | input | 1 | Qualifies the bus word for sample or compression |
| mode_i | input | 2 | 00 hold, 01 sample, 10 signature, 11 hold |
| start_i | input | 1 | Clears the word to zero |
| mask_i | input | WIDTH | 1 removes that bus bit from compression |
| taps_i | input | WIDTH | Feedback tap word (polynomial) |
| scan_en_i | input | 1 | Serial shift enable |
| scan_in_i | input | 1 | Serial data into bit WIDTH-1 |
| scan_out_o | output | 1 | Serial data out, bit 0 of the word |
| sig_o | output | WIDTH | Parallel view of the word |

## Verification
Assertions check the following on every cycle:
- the clear after start;
- the one-place scan shift and its priority;
- the sample load;
- holding when nothing is qualified;
- that a fully masked word with zero taps gives only a plain shift.

Whether the masked lines truly vanish from a long mixed stream, and whether each tap word gives the right polynomial, can only be seen through the bench's scenarios. The bench compares whole signature sequences against an arithmetic model and against runs that differ only in masked bits.

// File: rtl/sigan_pkg.sv
package sigan_pkg;

   typedef enum logic [1:0] {
      MODE_HOLD   = 2'b00,
      MODE_SAMPLE = 2'b01,
      MODE_SIGN   = 2'b10,
      MODE_RSVD   = 2'b11
   } sig_mode_e;

   localparam int FB_GALOIS    = 0;
   localparam int FB_FIBONACCI = 1;

   typedef enum logic [2:0] {
      ACT_HOLD,
      ACT_CLEAR,
      ACT_SCAN,
      ACT_LOAD,
      ACT_FOLD
   } cell_act_e;

endpackage

// File: rtl/sigan_mask.sv
module sigan_mask #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] bus_i,
   input  logic [WIDTH-1:0] mask_i,
   output logic [WIDTH-1:0] data_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("sigan_mask: WIDTH must be at least 2");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_lane
      assign data_o[b] = bus_i[b] & ~mask_i[b];
   end

endmodule

// File: rtl/sigan_feedback.sv
module sigan_feedback #(
   parameter int WIDTH    = 16,
   parameter int FB_STYLE = sigan_pkg::FB_GALOIS
) (
   input  logic [WIDTH-1:0] cur_i,
   input  logic [WIDTH-1:0] taps_i,
   input  logic [WIDTH-1:0] data_i,
   output logic [WIDTH-1:0] next_o
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sigan_feedback: WIDTH must be at least 2");
   end
   if (FB_STYLE != sigan_pkg::FB_GALOIS && FB_STYLE != sigan_pkg::FB_FIBONACCI) begin : g_bad_style
      $error("sigan_feedback: unknown FB_STYLE");
   end

   logic [WIDTH-1:0] shifted;
   logic [WIDTH-1:0] fb_word;

   if (FB_STYLE == sigan_pkg::FB_GALOIS) begin : g_galois
      // the bit leaving the top is spread onto every tapped position
      assign shifted = {cur_i[MSB-1:0], 1'b0};
      assign fb_word = cur_i[MSB] ? taps_i : '0;
   end else begin : g_fibonacci
      // parity of the tapped positions enters at bit 0
      logic par;
      assign par     = ^(cur_i & taps_i);
      assign shifted = {cur_i[MSB-1:0], 1'b0};
      assign fb_word = {{(WIDTH-1){1'b0}}, par};
   end

   assign next_o = shifted ^ fb_word ^ data_i;

endmodule

// File: rtl/sigan_cell.sv
module sigan_cell #(
   parameter int WIDTH = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  sigan_pkg::cell_act_e act_i,
   input  logic                scan_in_i,
   input  logic [WIDTH-1:0]    load_i,
   input  logic [WIDTH-1:0]    fold_i,
   output logic [WIDTH-1:0]    word_o
);

   import sigan_pkg::*;

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sigan_cell: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] word_q;
   logic [WIDTH-1:0] word_d;

   always_comb begin
      word_d = word_q;
      unique case (act_i)
         ACT_CLEAR: word_d = '0;
         ACT_SCAN:  word_d = {scan_in_i, word_q[MSB:1]};
         ACT_LOAD:  word_d = load_i;
         ACT_FOLD:  word_d = fold_i;
         default:   word_d = word_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
   end

   assign word_o = word_q;

   p_scan_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
      act_i == ACT_SCAN |=> word_q == {$past(scan_in_i), $past(word_q[MSB:1])});

   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      act_i == ACT_LOAD |=> word_q == $past(load_i));

endmodule

// File: rtl/masked_sig_analyzer.sv
module masked_sig_analyzer #(
   parameter int WIDTH    = 16,
   parameter int FB_STYLE = sigan_pkg::FB_GALOIS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] bus_i,
   input  logic             strobe_i,
   input  logic [1:0]       mode_i,
   input  logic             start_i,
   input  logic [WIDTH-1:0] mask_i,
   input  logic [WIDTH-1:0] taps_i,
   input  logic             scan_en_i,
   input  logic             scan_in_i,
   output logic             scan_out_o,
   output logic [WIDTH-1:0] sig_o
);

   import sigan_pkg::*;

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("masked_sig_analyzer: WIDTH must be at least 2");
   end

   sig_mode_e        mode;
   cell_act_e        act;
   logic [WIDTH-1:0] data_m;
   logic [WIDTH-1:0] fold_w;
   logic [WIDTH-1:0] word;

   assign mode = sig_mode_e'(mode_i);

   // priority: clear, then scan, then qualified capture or fold
   always_comb begin
      act = ACT_HOLD;
      if (start_i)                             act = ACT_CLEAR;
      else if (scan_en_i)                      act = ACT_SCAN;
      else if (strobe_i && mode == MODE_SAMPLE) act = ACT_LOAD;
      else if (strobe_i && mode == MODE_SIGN)   act = ACT_FOLD;
   end

   sigan_mask #(.WIDTH(WIDTH)) u_mask (
      .bus_i  (bus_i),
      .mask_i (mask_i),
      .data_o (data_m)
   );

   sigan_feedback #(.WIDTH(WIDTH), .FB_STYLE(FB_STYLE)) u_fb (
      .cur_i  (word),
      .taps_i (taps_i),
      .data_i (data_m),
      .next_o (fold_w)
   );

   sigan_cell #(.WIDTH(WIDTH)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (act),
      .scan_in_i (scan_in_i),
      .load_i    (bus_i),
      .fold_i    (fold_w),
      .word_o    (word)
   );

   assign sig_o      = word;
   assign scan_out_o = word[0];

   p_start_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> sig_o == '0);

   p_scan_priority_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en_i && !start_i) |=> sig_o[MSB-1:0] == $past(sig_o[MSB:1]));

   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !scan_en_i && (!strobe_i || mode_i == 2'b00 || mode_i == 2'b11))
      |=> $stable(sig_o));

   p_masked_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !scan_en_i && strobe_i && mode_i == 2'b10 &&
       (bus_i & ~mask_i) == '0 && taps_i == '0)
      |=> sig_o == {$past(sig_o[MSB-1:0]), 1'b0});

   always_comb begin
      if (rst_n) begin
         a_scan_bit_r3: assert (scan_out_o == sig_o[0]);
      end
   end

endmodule

// File: tb/masked_sig_analyzer_tb.sv
module masked_sig_analyzer_tb;

   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] bus = '0;
   logic         strobe = 1'b0;
   logic [1:0]   mode = 2'b00;
   logic         start = 1'b0;
   logic [W-1:0] mask = '0;
   logic [W-1:0] taps = '0;
   logic         scan_en = 1'b0;
   logic         scan_in = 1'b0;
   logic         scan_out;
   logic [W-1:0] sig;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   masked_sig_analyzer #(.WIDTH(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_i(bus), .strobe_i(strobe), .mode_i(mode),
      .start_i(start), .mask_i(mask), .taps_i(taps), .scan_en_i(scan_en),
      .scan_in_i(scan_in), .scan_out_o(scan_out), .sig_o(sig)
   );

   function automatic logic [W-1:0] model(logic [W-1:0] cur, logic [W-1:0] tp,
                                          logic [W-1:0] d, logic [W-1:0] m);
      return {cur[W-2:0], 1'b0} ^ (cur[W-1] ? tp : '0) ^ (d & ~m);
   endfunction

   function automatic logic [W-1:0] prng(logic [W-1:0] s);
      return {s[W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // inputs change 2 ns after an edge; outputs read there reflect that edge
   task automatic cyc();
      @(posedge clk);
      #2;
   endtask

   task automatic idle();
      strobe = 0; mode = 2'b00; start = 0; scan_en = 0; scan_in = 0;
   endtask

   task automatic clear();
      idle(); start = 1; cyc(); start = 0;
   endtask

   // run n folds from seed s; returns final signature, checks each step
   task automatic run_sig(int n, logic [W-1:0] s, logic [W-1:0] flip,
                          string req, output logic [W-1:0] fin);
      logic [W-1:0] exp_v;
      logic [W-1:0] d;
      clear();
      exp_v = '0;
      d = s;
      mode = 2'b10; strobe = 1;
      for (int i = 0; i < n; i++) begin
         bus = d ^ flip;
         cyc();
         exp_v = model(exp_v, taps, d ^ flip, mask);
         chk(req, sig, exp_v);
         d = prng(d);
      end
      idle();
      fin = sig;
   endtask

   initial begin
      logic [W-1:0] a, b, e, got;
      #1;
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      cyc();
      // R1 reset state
      chk("R1", sig, '0);
      chk("R1 scan_out", {15'd0, scan_out}, '0);

      // R5 sample sweep over walking ones and patterns
      for (int k = 0; k < W; k++) begin
         idle(); mode = 2'b01; strobe = 1; bus = 16'h1 << k;
         cyc();
         chk("R5 sample walk", sig, 16'h1 << k);
      end
      bus = 16'hA5C3; cyc(); chk("R5 sample pattern", sig, 16'hA5C3);

      // R8 hold: strobe low, and modes 00/11 with strobe
      idle(); mode = 2'b01; bus = 16'h0F0F; cyc();
      chk("R8 strobe low", sig, 16'hA5C3);
      strobe = 1; mode = 2'b00; cyc(); chk("R8 mode 00", sig, 16'hA5C3);
      mode = 2'b11; cyc(); chk("R8 mode 11", sig, 16'hA5C3);
      mode = 2'b10; strobe = 0; cyc(); chk("R8 sign strobe low", sig, 16'hA5C3);

      // R3 scan out LSB first, then loop back restores
      idle(); mode = 2'b01; strobe = 1; bus = 16'h8C31; cyc();
      idle(); scan_en = 1;
      got = '0;
      for (int k = 0; k < W; k++) begin
         got[k] = scan_out;
         scan_in = scan_out;
         cyc();
      end
      chk("R3 serial bits", got, 16'h8C31);
      chk("R3 loopback", sig, 16'h8C31);

      // R3 serial load of a seed, R4 strobe ignored during scan
      e = 16'h5E29;
      mode = 2'b01; strobe = 1; bus = 16'hFFFF;
      for (int k = 0; k < W; k++) begin
         scan_in = e[k];
         cyc();
      end
      chk("R4 scan priority", sig, e);

      // R2 start overrides scan and fold
      scan_en = 1; start = 1; mode = 2'b10; cyc();
      chk("R2 start clear", sig, '0);
      idle();

      // R6 and R9: fold streams across several tap words
      mask = '0;
      foreach (a[i]) a[i] = 1'b0;
      for (int t = 0; t < 5; t++) begin
         case (t)
            0: taps = 16'h1021;
            1: taps = 16'h8005;
            2: taps = 16'h002D;
            3: taps = 16'hFFFF;
            default: taps = 16'h0000;
         endcase
         run_sig(40, 16'hACE1 + 16'(t), '0, "R6/R9 fold", got);
      end
      taps = 16'h1021;
      run_sig(30, 16'h1234, '0, "R9 taps A", a);
      taps = 16'h8005;
      run_sig(30, 16'h1234, '0, "R9 taps B", b);
      total++;
      if (a == b) begin
         bad++;
         $display("FAIL R9: actual=%h expected!=%h", a, b);
      end

      // R7 each single masked bit: flipping it leaves the signature alone
      taps = 16'h1021;
      for (int k = 0; k < W; k++) begin
         mask = 16'h1 << k;
         run_sig(24, 16'h7A3B, '0, "R7 base", a);
         run_sig(24, 16'h7A3B, 16'h1 << k, "R7 flipped", b);
         chk("R7 masked bit no effect", b, a);
      end
      mask = 16'hF0F0;
      run_sig(24, 16'h0BAD, '0, "R7 base multi", a);
      run_sig(24, 16'h0BAD, 16'hF0F0, "R7 flipped multi", b);
      chk("R7 multi mask", b, a);

      // R2 start in the middle of a fold stream, then fold from zero
      mask = '0;
      mode = 2'b10; strobe = 1; bus = 16'h4321; start = 1; cyc();
      chk("R2 start over fold", sig, '0);
      start = 0; cyc();
      chk("R6 after clear", sig, model('0, taps, 16'h4321, '0));
      idle();

      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #1500000;
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule